// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block sequences the external memory bus of an 8-bit controller whose machine cycle is twelve oscillator clocks. It produces the address-latch strobe, the program-store strobe for code reads, and the read and write strobes for data. The low address byte and the data share one 8-bit port. The upper address byte leaves on a separate 8-bit port. Each machine cycle is either a fetch cycle, which holds two code-fetch slots of six clocks each, or a data cycle, which carries one external data access.

In a fetch cycle the block takes the program counter at the start of each slot. If the slot is external, it puts the address on the ports and pulses the program-store strobe. Slots served from internal memory leave that strobe idle, but the latch strobe keeps its six-clock rhythm. Data requests enter on a valid/ready stream that is open only on the last clock of a machine cycle. An accepted request turns the next machine cycle into a data cycle. That cycle has one latch pulse instead of two and no program-store pulses. Read data leaves on a valid/ready response stream. While a response is still waiting, no new data request is accepted unless `rsp_ready` is high in that same clock.

All outputs are registered. Output phase p of a machine cycle (p = 0..11) is the (p+2)-th clock edge after the edge on which that cycle's request was accepted or its first fetch address was sampled, counting that sampling edge as 1. Put another way, outputs trail the internal phase by one clock.

Top module: `ebus_seq`

## Requirements
- R1: In a fetch cycle, `ale` is high at phases 0-1 and 6-7 and low otherwise. The pulse is therefore two clocks wide and repeats every six clocks.
- R2: In a data cycle, `ale` is high only at phases 0-1, and `psen_n` stays high for all twelve phases.
- R3: For an external slot, `psen_n` is low at slot positions 3-5, which are phases 3-5 and 9-11. For an internal slot, or when `fetch_en` is low, `psen_n` stays high. `psen_n` is never low while `rd_n` or `wr_n` is low.
- R4: A slot is external when `fetch_en` is high and either `ext_only_n` is low or the program counter is above 0x0FFF. A counter of exactly 0x0FFF with `ext_only_n` high is internal, and 0x1000 is external.
- R5: For an external slot, `lo_oe` is high at slot positions 0-2 with `lo_out` equal to the counter's low byte. `lo_oe` is low at positions 3-5.
- R6: For an external slot, `hi_out` carries the counter's high byte. For an internal slot, it carries the `hi_latch` value sampled at the start of the slot.
- R7: In a data cycle, `hi_out` carries the upper address byte if `xreq_wide` is 1, and the sampled `hi_latch` if `xreq_wide` is 0. `lo_out` carries the low address byte with `lo_oe` high at phases 0-2.
- R8: In a read data cycle (`xreq_write` = 0), `rd_n` is low at phases 3-9 and `lo_oe` is low from phase 3 onward. The value on `lo_in` at phase 9 is returned on `rsp_data`, with `rsp_valid` rising at phase 10.
- R9: In a write data cycle, `wr_n` is low at phases 3-9 and `lo_out` carries the write data with `lo_oe` high at phases 3-10. `rd_n` stays high.
- R10: `xreq_ready` is high only on the last clock of a machine cycle. It is also low on that clock if `rsp_valid` is high and `rsp_ready` is low. A request that is not accepted leaves the next cycle a fetch cycle, and leaves the pending response unchanged.
- R11: In reset, `ale` = 0, `psen_n` = `rd_n` = `wr_n` = 1, `lo_oe` = 0 and `rsp_valid` = 0. These idle values stay on the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_only_n | input | 1 | Low forces every fetch to the external bus |
| fetch_en | input | 1 | A code fetch is wanted in the slot being started |
| fetch_pc | input | 16 | Program counter, sampled at each slot start |
| hi_latch | input | 8 | Upper-port latch value used when no address byte is needed |
| xreq_valid | input | 1 | Data access request valid |
| xreq_ready | output | 1 | Data access request accepted this clock |
| xreq_write | input | 1 | 1 = write, 0 = read |
| xreq_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit indirect address |
| xreq_addr | input | 16 | Data address |
| xreq_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 8 | Read data |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low address/data byte driven to the pad |
| lo_oe | output | 1 | Output enable for `lo_out` |
| lo_in | input | 8 | Value read back from the low pad |
| hi_out | output | 8 | Upper address byte or latch value |

## Verification
The hardest case to reach is a request that arrives while an earlier read response is still held. The stream must refuse the request, the cycle must fall back to plain fetches, and the held data must survive unchanged. The stimulus reaches this state by finishing a read while `rsp_ready` is low and offering a write request on the next boundary. It then releases the response on the boundary after that, where the request must be accepted in the same clock. The counter boundary at 0x0FFF/0x1000 is reached by placing the two values in the two slots of a single fetch cycle.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic {
    CYC_FETCH = 1'b0,
    CYC_DATA  = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr
  import ebus_pkg::*;
#(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xreq_valid,
  input  logic          rsp_hold,
  output logic [PW-1:0] ph_q,
  output cyc_kind_e     kind_q,
  output logic          xreq_ready,
  output logic          accept,
  output logic          slot_start
);
  localparam logic [PW-1:0] P_LAST = PW'(PHASES - 1);
  localparam logic [PW-1:0] P_MID  = PW'(PHASES / 2 - 1);

  // request window: last clock of a machine cycle, no stuck response
  assign xreq_ready = (ph_q == P_LAST) && !rsp_hold;
  assign accept     = xreq_valid && xreq_ready;
  assign slot_start = ((ph_q == P_LAST) && !accept) ||
                      ((ph_q == P_MID) && (kind_q == CYC_FETCH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= P_LAST;
      kind_q <= CYC_FETCH;
    end else begin
      if (ph_q == P_LAST) begin
        ph_q   <= '0;
        kind_q <= accept ? CYC_DATA : CYC_FETCH;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assert_ready_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_ready |=> (ph_q == '0));
  assert_accept_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (kind_q == CYC_DATA));
endmodule

// File: rtl/ebus_fetch_sel.sv
module ebus_fetch_sel #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] INT_TOP = 16'h0FFF,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_start,
  input  logic          accept,
  input  logic          ext_only_n,
  input  logic          fetch_en,
  input  logic [AW-1:0] fetch_pc,
  input  logic [HW-1:0] hi_latch,
  output logic          slot_ext,
  output logic [DW-1:0] slot_lo,
  output logic [HW-1:0] slot_hi
);
  logic go_ext;

  assign go_ext = fetch_en && (!ext_only_n || (fetch_pc > INT_TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_ext <= 1'b0;
      slot_lo  <= '0;
      slot_hi  <= '1;
    end else if (accept) begin
      slot_ext <= 1'b0;
    end else if (slot_start) begin
      slot_ext <= go_ext;
      slot_lo  <= fetch_pc[DW-1:0];
      slot_hi  <= go_ext ? fetch_pc[AW-1:DW] : hi_latch;
    end
  end

  assert_forced_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !accept && fetch_en && !ext_only_n) |=> slot_ext);
  assert_idle_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !fetch_en) |=> !slot_ext);
endmodule

// File: rtl/ebus_dreq_latch.sv
module ebus_dreq_latch #(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          xreq_write,
  input  logic          xreq_wide,
  input  logic [AW-1:0] xreq_addr,
  input  logic [DW-1:0] xreq_wdata,
  input  logic [HW-1:0] hi_latch,
  output logic          dq_write,
  output logic [DW-1:0] dq_lo,
  output logic [HW-1:0] dq_hi,
  output logic [DW-1:0] dq_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_write <= 1'b0;
      dq_lo    <= '0;
      dq_hi    <= '1;
      dq_wdata <= '0;
    end else if (accept) begin
      dq_write <= xreq_write;
      dq_lo    <= xreq_addr[DW-1:0];
      dq_hi    <= xreq_wide ? xreq_addr[AW-1:DW] : hi_latch;
      dq_wdata <= xreq_wdata;
    end
  end
endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_pkg::*;
#(
  parameter int PHASES  = 12,
  parameter int DW      = 8,
  parameter int HW      = 8,
  parameter int ALE_LEN = 2,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ph_q,
  input  cyc_kind_e     kind_q,
  input  logic          slot_ext,
  input  logic [DW-1:0] slot_lo,
  input  logic [HW-1:0] slot_hi,
  input  logic          dq_write,
  input  logic [DW-1:0] dq_lo,
  input  logic [HW-1:0] dq_hi,
  input  logic [DW-1:0] dq_wdata,
  input  logic [DW-1:0] lo_in,
  input  logic          rsp_ready,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          lo_oe,
  output logic [DW-1:0] lo_out,
  output logic [HW-1:0] hi_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam logic [PW-1:0] P_HALF     = PW'(PHASES / 2);
  localparam logic [PW-1:0] P_ALE      = PW'(ALE_LEN);
  localparam logic [PW-1:0] P_ADDR     = PW'(ALE_LEN + 1);
  localparam logic [PW-1:0] P_STB_LAST = PW'(PHASES - 3);
  localparam logic [PW-1:0] P_WD_LAST  = PW'(PHASES - 2);

  logic [PW-1:0] q;
  logic          in_stb, capture;
  logic          ale_d, psen_d, rd_d, wr_d, oe_d;
  logic [DW-1:0] lo_d;
  logic [HW-1:0] hi_d;

  assign q       = (ph_q >= P_HALF) ? (ph_q - P_HALF) : ph_q;
  assign in_stb  = (ph_q >= P_ADDR) && (ph_q <= P_STB_LAST);
  assign capture = (kind_q == CYC_DATA) && !dq_write && (ph_q == P_WD_LAST);

  always_comb begin
    ale_d  = 1'b0;
    psen_d = 1'b1;
    rd_d   = 1'b1;
    wr_d   = 1'b1;
    oe_d   = 1'b0;
    lo_d   = slot_lo;
    hi_d   = slot_hi;
    if (kind_q == CYC_FETCH) begin
      ale_d  = (q < P_ALE);
      psen_d = !(slot_ext && (q >= P_ADDR));
      oe_d   = slot_ext && (q < P_ADDR);
    end else begin
      ale_d = (ph_q < P_ALE);
      rd_d  = !(in_stb && !dq_write);
      wr_d  = !(in_stb && dq_write);
      oe_d  = (ph_q < P_ADDR) || (dq_write && (ph_q <= P_WD_LAST));
      lo_d  = (ph_q < P_ADDR) ? dq_lo : dq_wdata;
      hi_d  = dq_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      lo_oe  <= 1'b0;
      lo_out <= '0;
      hi_out <= '1;
    end else begin
      ale    <= ale_d;
      psen_n <= psen_d;
      rd_n   <= rd_d;
      wr_n   <= wr_d;
      lo_oe  <= oe_d;
      lo_out <= lo_d;
      hi_out <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_data  <= lo_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_ale_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);
  assert_psen_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));
  assert_psen_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> $past(slot_ext));
  assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);
  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int PHASES  = 12,
  parameter int ALE_LEN = 2,
  parameter logic [AW-1:0] INT_TOP = 16'h0FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_only_n,
  input  logic             fetch_en,
  input  logic [AW-1:0]    fetch_pc,
  input  logic [AW-DW-1:0] hi_latch,
  input  logic             xreq_valid,
  output logic             xreq_ready,
  input  logic             xreq_write,
  input  logic             xreq_wide,
  input  logic [AW-1:0]    xreq_addr,
  input  logic [DW-1:0]    xreq_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    lo_out,
  output logic             lo_oe,
  input  logic [DW-1:0]    lo_in,
  output logic [AW-DW-1:0] hi_out
);
  localparam int HW = AW - DW;
  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] ph_q;
  cyc_kind_e     kind_q;
  logic          accept, slot_start, rsp_hold;
  logic          slot_ext;
  logic [DW-1:0] slot_lo, dq_lo, dq_wdata;
  logic [HW-1:0] slot_hi, dq_hi;
  logic          dq_write;

  assign rsp_hold = rsp_valid && !rsp_ready;

  ebus_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .xreq_valid(xreq_valid), .rsp_hold(rsp_hold),
    .ph_q(ph_q), .kind_q(kind_q), .xreq_ready(xreq_ready),
    .accept(accept), .slot_start(slot_start)
  );

  ebus_fetch_sel #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) u_fetch (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .accept(accept),
    .ext_only_n(ext_only_n), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
    .hi_latch(hi_latch), .slot_ext(slot_ext), .slot_lo(slot_lo),
    .slot_hi(slot_hi)
  );

  ebus_dreq_latch #(.AW(AW), .DW(DW)) u_dreq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .xreq_write(xreq_write),
    .xreq_wide(xreq_wide), .xreq_addr(xreq_addr), .xreq_wdata(xreq_wdata),
    .hi_latch(hi_latch), .dq_write(dq_write), .dq_lo(dq_lo),
    .dq_hi(dq_hi), .dq_wdata(dq_wdata)
  );

  ebus_strobe_gen #(.PHASES(PHASES), .DW(DW), .HW(HW), .ALE_LEN(ALE_LEN)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ph_q(ph_q), .kind_q(kind_q),
    .slot_ext(slot_ext), .slot_lo(slot_lo), .slot_hi(slot_hi),
    .dq_write(dq_write), .dq_lo(dq_lo), .dq_hi(dq_hi), .dq_wdata(dq_wdata),
    .lo_in(lo_in), .rsp_ready(rsp_ready),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_oe(lo_oe), .lo_out(lo_out), .hi_out(hi_out),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/ebus_seq_tb.sv
module ebus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_only_n = 1'b1;
  logic        fetch_en = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [7:0]  hi_latch = 8'hFF;
  logic        xreq_valid = 1'b0;
  logic        xreq_ready;
  logic        xreq_write = 1'b0;
  logic        xreq_wide = 1'b0;
  logic [15:0] xreq_addr = '0;
  logic [7:0]  xreq_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;
  logic        ale, psen_n, rd_n, wr_n, lo_oe;
  logic [7:0]  lo_out, hi_out;
  logic [7:0]  lo_in = '0;

  int tests = 0;
  int fails = 0;
  logic [20:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;
  logic [7:0]  pend_data = '0;

  ebus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ext_only_n(ext_only_n), .fetch_en(fetch_en),
    .fetch_pc(fetch_pc), .hi_latch(hi_latch), .xreq_valid(xreq_valid),
    .xreq_ready(xreq_ready), .xreq_write(xreq_write), .xreq_wide(xreq_wide),
    .xreq_addr(xreq_addr), .xreq_wdata(xreq_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
    .hi_out(hi_out)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {ale,psen_n,rd_n,wr_n,lo_oe,lo_out,hi_out} for output phase p
  function automatic logic [20:0] model(input int p, input logic isd, input logic wr,
      input logic wide, input logic [15:0] addr, input logic [7:0] wd,
      input logic ea_n, input logic fen, input logic [15:0] pca,
      input logic [15:0] pcb, input logic [7:0] hil);
    logic a, ps, r, w, oe, ext;
    logic [7:0] lo, hi;
    logic [15:0] pc;
    int q;
    a = 0; ps = 1; r = 1; w = 1; oe = 0; lo = 0; hi = hil;
    if (!isd) begin
      q   = p % 6;
      pc  = (p < 6) ? pca : pcb;
      ext = fen && (!ea_n || pc > 16'h0FFF);
      a   = (q < 2);
      ps  = !(ext && q >= 3);
      oe  = ext && q < 3;
      lo  = pc[7:0];
      hi  = ext ? pc[15:8] : hil;
    end else begin
      a  = (p < 2);
      r  = !(!wr && p >= 3 && p <= 9);
      w  = !(wr && p >= 3 && p <= 9);
      oe = (p < 3) || (wr && p <= 10);
      lo = (p < 3) ? addr[7:0] : wd;
      hi = wide ? addr[15:8] : hil;
    end
    if (!oe) lo = '0;
    return {a, ps, r, w, oe, lo, hi};
  endfunction

  // driver: called on the negedge where the phase is at the cycle's last clock
  task automatic run_cycle(input string tag, input logic isd, input logic wr,
      input logic wide, input logic [15:0] addr, input logic [7:0] wd,
      input logic [7:0] lin, input logic ea_n, input logic fen,
      input logic [15:0] pca, input logic [15:0] pcb, input logic [7:0] hil,
      input logic rdy);
    logic exp_rdy, acc;
    xreq_valid = isd; xreq_write = wr; xreq_wide = wide; xreq_addr = addr;
    xreq_wdata = wd; lo_in = lin; ext_only_n = ea_n; fetch_en = fen;
    fetch_pc = pca; hi_latch = hil; rsp_ready = rdy;
    #1;
    exp_rdy = !pend || rdy;
    check({tag, " R10 ready"}, {31'b0, xreq_ready}, {31'b0, exp_rdy});
    acc = isd && exp_rdy;
    if (pend && rdy) pend = 1'b0;
    for (int p = 0; p < 12; p++) begin
      exp_q.push_back(model(p, acc, wr, wide, addr, wd, ea_n, fen, pca, pcb, hil));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    xreq_valid = 1'b0;
    repeat (5) @(negedge clk);
    fetch_pc = pcb;
    repeat (6) @(negedge clk);
    if (acc && !wr) begin
      pend = 1'b1;
      pend_data = lin;
    end
    check({tag, " R8 rsp_valid"}, {31'b0, rsp_valid}, {31'b0, pend});
    if (pend) check({tag, " R8 rsp_data"}, {24'b0, rsp_data}, {24'b0, pend_data});
  endtask

  // monitor: pops one expected record per clock and compares
  initial begin
    @(posedge clk iff rst_n);
    @(negedge clk);
    check("R11 first clock ale", {31'b0, ale}, 32'd0);
    check("R11 first clock psen_n", {31'b0, psen_n}, 32'd1);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [20:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {ale, psen_n, rd_n, wr_n, lo_oe, (lo_oe ? lo_out : 8'h00), hi_out};
        check({t, " strobes/ports"}, {11'b0, a}, {11'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset ale", {31'b0, ale}, 32'd0);
    check("R11 reset psen_n", {31'b0, psen_n}, 32'd1);
    check("R11 reset rd_n/wr_n", {30'b0, rd_n, wr_n}, 32'd3);
    check("R11 reset lo_oe", {31'b0, lo_oe}, 32'd0);
    check("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 R3 R6: internal fetches, hi port shows latch, no program strobe
    run_cycle("R1 R3 R6 internal", 0, 0, 0, 0, 0, 0, 1, 1, 16'h0100, 16'h0101, 8'h3C, 1);
    // R4 R5 R6: forced external fetch of low addresses
    run_cycle("R4 R5 R6 forced ext", 0, 0, 0, 0, 0, 0, 0, 1, 16'h0234, 16'h0235, 8'h3C, 1);
    // R4: boundary 0x0FFF internal, 0x1000 external
    run_cycle("R4 boundary", 0, 0, 0, 0, 0, 0, 1, 1, 16'h0FFF, 16'h1000, 8'h51, 1);
    // R3: no fetch wanted
    run_cycle("R3 no fetch", 0, 0, 0, 0, 0, 0, 0, 0, 16'h2000, 16'h2001, 8'h66, 1);
    // R2 R7 R8: wide read
    run_cycle("R2 R7 R8 wide read", 1, 0, 1, 16'hABCD, 8'h00, 8'h5A, 1, 1, 16'h0000, 16'h0000, 8'h11, 1);
    // R7 R9: narrow write, hi port shows latch
    run_cycle("R7 R9 narrow write", 1, 1, 0, 16'h0042, 8'hC3, 8'h00, 1, 1, 16'h0000, 16'h0000, 8'h77, 1);
    // R8: narrow read, response held
    run_cycle("R8 narrow read held", 1, 0, 0, 16'h0012, 8'h00, 8'h9E, 0, 1, 16'h0000, 16'h0000, 8'h24, 0);
    // R10: request refused while response is held; fetches continue
    run_cycle("R10 blocked", 1, 1, 1, 16'h4455, 8'hAA, 8'h01, 0, 1, 16'h3000, 16'h3001, 8'h24, 0);
    // R10: response taken in the accepting clock, wide write accepted
    run_cycle("R10 release R9", 1, 1, 1, 16'h8001, 8'h5C, 8'h00, 0, 1, 16'h0000, 16'h0000, 8'h24, 1);
    // R1 R5: external fetch after data traffic
    run_cycle("R1 R5 ext again", 0, 0, 0, 0, 0, 0, 1, 1, 16'hF00D, 16'hF00E, 8'h00, 1);
    fetch_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule